// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block watches every data memory reference that the execution pipeline presents to it. For each reference it decides whether an alignment-check exception has to be raised. It takes in the byte address and the operand size of the reference. It also takes in the conditions that turn checking on: the alignment flag from the flags register, the alignment-mask bit from the control register, and the current privilege level. A marker tells it when a reference is an implicit supervisor-level access, such as a descriptor-table load. Such a reference is never checked, even when a user-mode instruction issues it.

One reference can arrive per cycle, qualified by a valid bit. The block registers the result. In the cycle after a faulting reference it pulses an exception request for one cycle. It also holds the faulting address in a register until the next fault replaces it. Address translation, the access itself and the delivery of the exception are done elsewhere.

Top module: `align_check_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `fault_req` is 0 and `fault_addr` is all zeros.
- R2: `fault_req` is high in exactly the cycle after a clock edge that samples a reference meeting every fault condition. Those conditions are: `ref_valid` = 1, `flag_ac` = 1, `ctl_amask` = 1, `ref_cpl` = 3, `ref_sys_implicit` = 0, and a misaligned address. At every other time `fault_req` is low.
- R3: Checking is active only when `flag_ac` and `ctl_amask` are both 1. If either one is 0, no reference raises `fault_req`.
- R4: A reference with `ref_cpl` of 0, 1 or 2 never raises `fault_req`. Only privilege level 3 is checked.
- R5: A reference with `ref_sys_implicit` = 1 never raises `fault_req`, whatever its privilege level.
- R6: A byte access (`ref_size` = 2'b00) is never misaligned.
- R7: A word access (`ref_size` = 2'b01) is misaligned exactly when address bit 0 is 1.
- R8: A doubleword access (`ref_size` = 2'b10) is misaligned exactly when address bits [1:0] are not 2'b00.
- R9: A quadword access (`ref_size` = 2'b11) is misaligned exactly when address bits [2:0] are not 3'b000.
- R10: When `fault_req` is high, `fault_addr` holds the full address of the reference that caused it. `fault_addr` keeps that value unchanged until the next fault.
- R11: A cycle with `ref_valid` = 0 never raises `fault_req`, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | ADDR_W | Byte address of the reference |
| ref_size | input | 2 | Operand size: 00 byte, 01 word, 10 doubleword, 11 quadword |
| ref_cpl | input | 2 | Current privilege level |
| ref_sys_implicit | input | 1 | Reference is an implicit supervisor-level access |
| flag_ac | input | 1 | Alignment-check flag from the flags register |
| ctl_amask | input | 1 | Alignment-mask bit from the control register |
| fault_req | output | 1 | One-cycle alignment-check exception request |
| fault_addr | output | ADDR_W | Address of the most recent faulting reference |

## Verification
The bench sweeps every combination of these inputs: all four size codes against all eight low-order address patterns, every privilege level, both enable bits, the implicit marker, and the valid bit.

- The size and address pairs separate the four alignment rules from one another. For example, address 2 is misaligned for a doubleword but not for a word, and address 4 is misaligned for a quadword but not for a doubleword.
- The enable, privilege, implicit and valid dimensions show that each gate on its own suppresses a fault that would otherwise occur.
- The high address bits change with every reference. This shows that the captured address is the full faulting address and that it stays put across references that do not fault.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;

    localparam int SIZE_W    = 2;
    localparam int NUM_SIZES = 4;
    localparam int LOW_W     = NUM_SIZES - 1;
    localparam int CPL_W     = 2;
    localparam logic [CPL_W-1:0] USER_CPL = 2'd3;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_QWORD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             valid;
        logic [CPL_W-1:0] cpl;
        logic             sys_implicit;
        acc_size_e        size;
    } ref_attr_t;

    // Low address bits that must be zero for an operand of the given size.
    function automatic logic [LOW_W-1:0] low_mask(input acc_size_e s);
        logic [LOW_W-1:0] m;
        case (s)
            SZ_BYTE:  m = 3'b000;
            SZ_WORD:  m = 3'b001;
            SZ_DWORD: m = 3'b011;
            default:  m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/align_enable_gate.sv
module align_enable_gate
    import align_chk_pkg::*;
(
    input  ref_attr_t attr,
    input  logic      flag_ac,
    input  logic      ctl_amask,
    output logic      check_on
);
    logic both_enabled;
    logic user_level;

    always_comb begin
        both_enabled = flag_ac & ctl_amask;
        user_level   = (attr.cpl == USER_CPL) & ~attr.sys_implicit;
        check_on     = attr.valid & both_enabled & user_level;
    end
endmodule

// File: rtl/align_misalign_detect.sv
module align_misalign_detect
    import align_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic              misaligned
);
    logic [LOW_W-1:0]     low_bits;
    logic [NUM_SIZES-1:0] per_size;

    assign low_bits = addr[LOW_W-1:0];

    // One detector per size code; the active size picks its result.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam logic [LOW_W-1:0] MASK = low_mask(acc_size_e'(g));
        assign per_size[g] = |(low_bits & MASK);
    end

    assign misaligned = per_size[size];

    logic unused_high;
    assign unused_high = ^addr[ADDR_W-1:LOW_W];
endmodule

// File: rtl/align_fault_reg.sv
module align_fault_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault_req,
    output logic [ADDR_W-1:0] fault_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_req  <= 1'b0;
            fault_addr <= '0;
        end else begin
            fault_req <= hit;
            if (hit) begin
                fault_addr <= addr;
            end
        end
    end
endmodule

// File: rtl/align_check_unit.sv
module align_check_unit
    import align_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [1:0]        ref_size,
    input  logic [1:0]        ref_cpl,
    input  logic              ref_sys_implicit,
    input  logic              flag_ac,
    input  logic              ctl_amask,
    output logic              fault_req,
    output logic [ADDR_W-1:0] fault_addr
);
    ref_attr_t attr;
    logic      check_on;
    logic      misaligned;
    logic      hit;

    always_comb begin
        attr.valid        = ref_valid;
        attr.cpl          = ref_cpl;
        attr.sys_implicit = ref_sys_implicit;
        attr.size         = acc_size_e'(ref_size);
    end

    align_enable_gate u_gate (
        .attr      (attr),
        .flag_ac   (flag_ac),
        .ctl_amask (ctl_amask),
        .check_on  (check_on)
    );

    align_misalign_detect #(.ADDR_W(ADDR_W)) u_detect (
        .addr       (ref_addr),
        .size       (attr.size),
        .misaligned (misaligned)
    );

    assign hit = check_on & misaligned;

    align_fault_reg #(.ADDR_W(ADDR_W)) u_freg (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .addr       (ref_addr),
        .fault_req  (fault_req),
        .fault_addr (fault_addr)
    );
endmodule

// File: rtl/align_check_unit_sva.sv
module align_check_unit_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_valid,
    input logic [ADDR_W-1:0] ref_addr,
    input logic [1:0]        ref_size,
    input logic [1:0]        ref_cpl,
    input logic              ref_sys_implicit,
    input logic              flag_ac,
    input logic              ctl_amask,
    input logic              fault_req,
    input logic [ADDR_W-1:0] fault_addr
);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> !fault_req);

    p_enable_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (!flag_ac || !ctl_amask) |=> !fault_req);

    p_kernel_levels_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_cpl != 2'd3) |=> !fault_req);

    p_implicit_exempt_r5: assert property (@(posedge clk) disable iff (rst)
        ref_sys_implicit |=> !fault_req);

    p_byte_never_r6: assert property (@(posedge clk) disable iff (rst)
        (ref_size == 2'b00) |=> !fault_req);

    p_word_even_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_size == 2'b01 && !ref_addr[0]) |=> !fault_req);

    p_fault_source_r2: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> ($past(ref_valid) && $past(ref_cpl) == 2'd3));

    p_addr_capture_r10: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> (fault_addr == $past(ref_addr)));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !fault_req |-> $stable(fault_addr));
endmodule

bind align_check_unit align_check_unit_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/align_check_unit_test.sv
module align_check_unit_test;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              ref_valid;
    logic [ADDR_W-1:0] ref_addr;
    logic [1:0]        ref_size;
    logic [1:0]        ref_cpl;
    logic              ref_sys_implicit;
    logic              flag_ac;
    logic              ctl_amask;
    logic              fault_req;
    logic [ADDR_W-1:0] fault_addr;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    align_check_unit #(.ADDR_W(ADDR_W)) uut (
        .clk              (clk),
        .rst              (rst),
        .ref_valid        (ref_valid),
        .ref_addr         (ref_addr),
        .ref_size         (ref_size),
        .ref_cpl          (ref_cpl),
        .ref_sys_implicit (ref_sys_implicit),
        .flag_ac          (flag_ac),
        .ctl_amask        (ctl_amask),
        .fault_req        (fault_req),
        .fault_addr       (fault_addr)
    );

    task automatic check_vec(input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp,
                             input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string fault_tag(input bit v, input bit ac, input bit am,
                                        input logic [1:0] cpl, input bit imp,
                                        input logic [1:0] sz, input bit exp);
        if (!v)              return "R11 valid low";
        if (!(ac && am))     return "R3 enable pair";
        if (cpl != 2'd3)     return "R4 privilege";
        if (imp)             return "R5 implicit";
        if (exp)             return "R2 fault raised";
        case (sz)
            2'b00:   return "R6 byte";
            2'b01:   return "R7 word";
            2'b10:   return "R8 doubleword";
            default: return "R9 quadword";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [ADDR_W-1:0] exp_addr;
        rst = 1'b1;
        ref_valid = 1'b0;
        ref_addr = '0;
        ref_size = 2'b00;
        ref_cpl = 2'd0;
        ref_sys_implicit = 1'b0;
        flag_ac = 1'b0;
        ctl_amask = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_vec({31'd0, fault_req}, '0, "R1 reset fault_req");
        check_vec(fault_addr, '0, "R1 reset fault_addr");
        rst = 1'b0;
        @(negedge clk);
        check_vec({31'd0, fault_req}, '0, "R1 after reset fault_req");
        check_vec(fault_addr, '0, "R1 after reset fault_addr");
        exp_addr = '0;

        for (int v = 0; v < 2; v++)
        for (int am = 0; am < 2; am++)
        for (int ac = 0; ac < 2; ac++)
        for (int imp = 0; imp < 2; imp++)
        for (int cpl = 0; cpl < 4; cpl++)
        for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 8; lo++) begin
            logic [ADDR_W-1:0] a;
            bit mis, exp_f;
            int n;
            n = ((((v * 2 + am) * 2 + ac) * 2 + imp) * 4 + cpl) * 32 + sz * 8 + lo;
            a = (32'(n) * 32'h9E37_79B1) & 32'hFFFF_FFF8;
            a = a | 32'(lo);
            mis = ((lo & ((1 << sz) - 1)) != 0);
            exp_f = (v == 1) && (ac == 1) && (am == 1) && (cpl == 3) && (imp == 0) && mis;
            ref_valid        = v[0];
            ref_addr         = a;
            ref_size         = sz[1:0];
            ref_cpl          = cpl[1:0];
            ref_sys_implicit = imp[0];
            flag_ac          = ac[0];
            ctl_amask        = am[0];
            @(negedge clk);
            if (exp_f) exp_addr = a;
            check_vec({31'd0, fault_req}, {31'd0, exp_f},
                      fault_tag(v[0], ac[0], am[0], cpl[1:0], imp[0], sz[1:0], exp_f));
            check_vec(fault_addr, exp_addr, "R10 captured address");
        end

        ref_valid = 1'b0;
        @(negedge clk);
        check_vec({31'd0, fault_req}, '0, "R2 single-cycle pulse");
        check_vec(fault_addr, exp_addr, "R10 hold after sweep");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule